// File: doc/BRIEF.md
# Prioritized Video Input Change-Over Controller

This controller decides which of up to three candidate video sources feeds the downstream path. The candidates are an optical input, an electrical input and an internal pattern generator. A short priority list, configured by software, names the order in which they are tried. For each physical input the block receives three status flags: carrier present, receiver locked and timing-reference error. It also receives a one-cycle strobe once per millisecond. It reports the source in use and the list position it came from.

In automatic mode the controller stays on a failed source for a hold time before it steps down the list. A source higher in the list must stay healthy for a lock time before the controller climbs back to it. A selectable rule sets how strict the health test is. An optional latch stops the controller from climbing back while the loss-of-signal rule is in force. The latch never keeps the generator on the output once a physical input has recovered. Manual mode pins the controller to a single operator-chosen source.

Top module: `failover_sel`

## Requirements
- R1: After reset, `level` is 0 and `src_sel` equals the first list entry.
- R2: Source codes: 0 = optical (flag bit 0), 1 = electrical (flag bit 1), 2 or 3 = generator, which is always healthy. A physical input is healthy under `rule_sel` as follows. With 0 (and with 3), carrier present is enough. With 1, carrier and lock are both needed. With 2, carrier and lock are needed and there must be no timing-reference error.
- R3: While the current entry is unhealthy and is not the last entry, the level steps down by one on the tick at which the count of consecutive unhealthy ticks reaches `hold_ms`. A `hold_ms` of 0 acts like 1.
- R4: The hold count restarts whenever the current entry becomes healthy before it expires.
- R5: On the last list entry the controller stays put, even when that entry is unhealthy.
- R6: If any entry above the current level is healthy, the controller moves to the highest such entry. It does so on the tick at which that same entry has stayed the best healthy candidate for `lock_ms` ticks. The count restarts if the candidate changes or disappears.
- R7: Every step down arms a latch. While the latch is armed, `latch_en` is 1, `rule_sel` is 0 and the current source is physical, the controller does not climb back.
- R8: With `latch_en` set and `rule_sel` other than 0, the controller climbs back as in R6.
- R9: A one-cycle `latch_clr` releases the latch. A climb-back then follows after `lock_ms` further ticks.
- R10: When the generator is the current source, the controller climbs back to a recovered physical input after `lock_ms` ticks, even with the latch armed.
- R11: With `manual` set, the list holds the single entry `man_src`. `level` stays 0 and `src_sel` equals `man_src`.
- R12: If a climb-back and a step-down both become due on the same tick, the climb-back is taken.
- R13: `prio_cnt` gives the list length: 0 or 1 means one entry, 2 means two, 3 means three. The list entries sit in `prio_list` with entry i at bits 2i+1:2i. If the level lies beyond the list end, it returns to 0 on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle millisecond strobe |
| sig_ok | input | 2 | Carrier present per physical input |
| lock_ok | input | 2 | Receiver locked per physical input |
| trs_err | input | 2 | Timing-reference error per physical input |
| rule_sel | input | 2 | Health rule select |
| prio_list | input | 6 | Priority list, 2-bit source codes |
| prio_cnt | input | 2 | List length |
| manual | input | 1 | Manual mode |
| man_src | input | 2 | Source used in manual mode |
| latch_en | input | 1 | Latch option |
| latch_clr | input | 1 | Latch release pulse |
| hold_ms | input | TW | Hold time in ticks |
| lock_ms | input | TW | Lock time in ticks |
| src_sel | output | 2 | Selected source code |
| level | output | 2 | Current list position |

## Verification
A step-down and a climb-back can come due on the same millisecond tick. This happens when the current source has been failing for almost the hold time and a better source has been healthy for almost the lock time. The bench provokes this at level 1 by making the optical input recover and the electrical input fail on the same edge, with both times set to 4 ticks. It then checks that the level is still 1 after three ticks. After the fourth tick it checks that the controller has gone up to level 0 and has not gone down to level 2.

// File: rtl/failover_sel.sv
module failover_sel #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_ms,
  input  logic [1:0]    sig_ok,
  input  logic [1:0]    lock_ok,
  input  logic [1:0]    trs_err,
  input  logic [1:0]    rule_sel,
  input  logic [5:0]    prio_list,
  input  logic [1:0]    prio_cnt,
  input  logic          manual,
  input  logic [1:0]    man_src,
  input  logic          latch_en,
  input  logic          latch_clr,
  input  logic [TW-1:0] hold_ms,
  input  logic [TW-1:0] lock_ms,
  output logic [1:0]    src_sel,
  output logic [1:0]    level
);
  logic [1:0]    level_q, cand_q, cand_i, nlen, hp;
  logic          latched_q, cand_vq, cand_v, same, block, fail, fall_go, ret_go;
  logic [TW-1:0] hold_cnt, lock_cnt, lk_base;
  logic [TW:0]   hd_inc, lk_inc;
  logic [1:0]    ent [4];
  logic [3:0]    ent_ok;

  assign hp = (rule_sel == 2'd1) ? (sig_ok & lock_ok) :
              (rule_sel == 2'd2) ? (sig_ok & lock_ok & ~trs_err) : sig_ok;
  assign nlen = manual ? 2'd1 : ((prio_cnt == 2'd0) ? 2'd1 : prio_cnt);

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      ent[i]    = manual ? man_src : prio_list[2*i +: 2];
      ent_ok[i] = ent[i][1] | hp[ent[i][0]];
    end
    ent[3]    = 2'd2;
    ent_ok[3] = 1'b1;
  end

  always_comb begin
    cand_v = 1'b0;
    cand_i = 2'd0;
    for (int i = 2; i >= 0; i--)
      if (2'(i) < level_q && ent_ok[i]) begin
        cand_v = 1'b1;
        cand_i = 2'(i);
      end
  end

  assign src_sel = ent[level_q];
  assign level   = level_q;

  assign block   = latched_q & latch_en & (rule_sel == 2'd0) & ~ent[level_q][1];
  assign same    = cand_v & cand_vq & (cand_i == cand_q);
  assign lk_base = same ? lock_cnt : '0;
  assign lk_inc  = {1'b0, lk_base} + 1'b1;
  assign ret_go  = tick_ms & cand_v & ~block & (lk_inc >= {1'b0, lock_ms});
  assign fail    = ~ent_ok[level_q] & (level_q < nlen - 2'd1);
  assign hd_inc  = {1'b0, hold_cnt} + 1'b1;
  assign fall_go = tick_ms & fail & (hd_inc >= {1'b0, hold_ms});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level_q   <= '0;
      hold_cnt  <= '0;
      lock_cnt  <= '0;
      cand_q    <= '0;
      cand_vq   <= 1'b0;
      latched_q <= 1'b0;
    end else begin
      if (level_q >= nlen) begin
        level_q  <= '0;
        hold_cnt <= '0;
        lock_cnt <= '0;
        cand_vq  <= 1'b0;
      end else if (ret_go) begin
        level_q  <= cand_i;
        hold_cnt <= '0;
        lock_cnt <= '0;
        cand_vq  <= 1'b0;
      end else if (fall_go) begin
        level_q   <= level_q + 2'd1;
        hold_cnt  <= '0;
        lock_cnt  <= '0;
        cand_vq   <= 1'b0;
        latched_q <= 1'b1;
      end else begin
        hold_cnt <= fail ? (tick_ms ? hd_inc[TW-1:0] : hold_cnt) : '0;
        lock_cnt <= (cand_v & ~block) ? (tick_ms ? lk_inc[TW-1:0] : lk_base) : '0;
        cand_q   <= cand_i;
        cand_vq  <= cand_v & ~block;
      end
      if (latch_clr) latched_q <= 1'b0;
    end
  end
endmodule

// File: rtl/failover_sel_chk.sv
module failover_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick_ms,
  input logic       manual,
  input logic [1:0] prio_cnt,
  input logic       latch_en,
  input logic       latch_clr,
  input logic [1:0] rule_sel,
  input logic [1:0] src_sel,
  input logic [1:0] level,
  input logic       latched
);
  logic [1:0] nlen;
  assign nlen = manual ? 2'd1 : ((prio_cnt == 2'd0) ? 2'd1 : prio_cnt);

  assert_step_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (level > $past(level)) |-> ($past(tick_ms) && level == 2'($past(level) + 2'd1)));

  assert_manual_level_R11: assert property (@(posedge clk) disable iff (!rst_n)
    manual |=> (level == 2'd0));

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (latched && latch_en && rule_sel == 2'd0 && !latch_clr && !src_sel[1] && level < nlen)
      |=> (level >= $past(level)));

  assert_gen_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel[1] && level < nlen) |=> (level <= $past(level)));

  assert_range_back_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (level >= nlen) |=> (level == 2'd0));
endmodule

bind failover_sel failover_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .manual(manual),
  .prio_cnt(prio_cnt), .latch_en(latch_en), .latch_clr(latch_clr),
  .rule_sel(rule_sel), .src_sel(src_sel), .level(level), .latched(latched_q)
);

// File: tb/failover_sel_test.sv
`timescale 1ns/1ps
module failover_sel_test;
  localparam int TW = 16;
  logic clk = 0, rst_n = 0, tick_ms = 0, manual = 0, latch_en = 0, latch_clr = 0;
  logic [1:0] sig_ok = 2'b11, lock_ok = 2'b11, trs_err = 2'b00, rule_sel = 2'd1;
  logic [1:0] prio_cnt = 2'd3, man_src = 2'd0;
  logic [5:0] prio_list = {2'd2, 2'd1, 2'd0};
  logic [TW-1:0] hold_ms = 16'd3, lock_ms = 16'd4;
  logic [1:0] src_sel, level;
  int checks = 0, failures = 0;

  failover_sel #(.TW(TW)) uut (.*);

  always #2.5 clk = ~clk;

  // {sig, lock, err, ticks, exp_src, exp_level}, rule loss-of-lock, hold 3, lock 4
  localparam logic [13:0] VEC [10] = '{
    {2'b11, 2'b11, 2'b00, 4'd2, 2'd0, 2'd0},
    {2'b11, 2'b10, 2'b00, 4'd2, 2'd0, 2'd0},
    {2'b11, 2'b10, 2'b00, 4'd1, 2'd1, 2'd1},
    {2'b11, 2'b00, 2'b00, 4'd3, 2'd2, 2'd2},
    {2'b11, 2'b10, 2'b00, 4'd3, 2'd2, 2'd2},
    {2'b11, 2'b10, 2'b00, 4'd1, 2'd1, 2'd1},
    {2'b11, 2'b11, 2'b00, 4'd4, 2'd0, 2'd0},
    {2'b01, 2'b11, 2'b00, 4'd5, 2'd0, 2'd0},
    {2'b00, 2'b11, 2'b00, 4'd3, 2'd1, 2'd1},
    {2'b00, 2'b11, 2'b00, 4'd3, 2'd2, 2'd2}
  };

  task automatic chk(input string tag, input logic [1:0] es, input logic [1:0] el);
    checks++;
    if (src_sel !== es || level !== el) begin
      failures++;
      $display("FAIL %s: src=%0d level=%0d expected src=%0d level=%0d", tag, src_sel, level, es, el);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(negedge clk) tick_ms = 1;
      @(negedge clk) tick_ms = 0;
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #500000;
    failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset", 2'd0, 2'd0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      sig_ok = VEC[i][13:12]; lock_ok = VEC[i][11:10]; trs_err = VEC[i][9:8];
      ticks(int'(VEC[i][7:4]));
      chk($sformatf("R3/R6 vector %0d", i), VEC[i][3:2], VEC[i][1:0]);
    end

    // R4 hold restart, loss-of-signal rule
    rule_sel = 2'd0; sig_ok = 2'b11; lock_ok = 2'b11; do_reset();
    sig_ok = 2'b10; ticks(2); sig_ok = 2'b11; ticks(1); sig_ok = 2'b10; ticks(2);
    chk("R4 hold restarted", 2'd0, 2'd0);
    ticks(1); chk("R4 hold expiry", 2'd1, 2'd1);

    // R6 lock restart when candidate drops
    sig_ok = 2'b11; ticks(3); sig_ok = 2'b10; ticks(1); sig_ok = 2'b11; ticks(3);
    chk("R6 lock restarted", 2'd1, 2'd1);
    ticks(1); chk("R6 climb back", 2'd0, 2'd0);

    // R2 loss-of-signal ignores lock and error
    lock_ok = 2'b00; trs_err = 2'b11; ticks(5);
    chk("R2 LOS ignores lock/err", 2'd0, 2'd0);
    // R2 timing-error rule
    lock_ok = 2'b11; trs_err = 2'b01; rule_sel = 2'd2; ticks(3);
    chk("R2 TRS rule", 2'd1, 2'd1);
    trs_err = 2'b00;

    // R5 last entry kept
    rule_sel = 2'd0; prio_cnt = 2'd2; sig_ok = 2'b11; do_reset();
    sig_ok = 2'b00; ticks(10);
    chk("R5 last entry", 2'd1, 2'd1);

    // R7 latch, R9 release
    prio_cnt = 2'd3; latch_en = 1; sig_ok = 2'b11; do_reset();
    sig_ok = 2'b10; ticks(3); chk("R7 fell", 2'd1, 2'd1);
    sig_ok = 2'b11; ticks(10); chk("R7 latched stays", 2'd1, 2'd1);
    @(negedge clk) latch_clr = 1; @(negedge clk) latch_clr = 0;
    ticks(3); chk("R9 release wait", 2'd1, 2'd1);
    ticks(1); chk("R9 released climb", 2'd0, 2'd0);

    // R8 latch inert under loss-of-lock
    rule_sel = 2'd1; do_reset();
    lock_ok = 2'b10; ticks(3); lock_ok = 2'b11; ticks(4);
    chk("R8 latch ignored", 2'd0, 2'd0);

    // R10 generator left even when latched
    rule_sel = 2'd0; do_reset();
    sig_ok = 2'b00; ticks(6); chk("R10 on generator", 2'd2, 2'd2);
    sig_ok = 2'b10; ticks(4); chk("R10 left generator", 2'd1, 2'd1);
    sig_ok = 2'b11; ticks(10); chk("R10 latch still holds", 2'd1, 2'd1);
    latch_en = 0;

    // R12 simultaneous expiry
    do_reset();
    sig_ok = 2'b10; ticks(3);
    @(negedge clk) hold_ms = 16'd4; sig_ok = 2'b01;
    ticks(3); chk("R12 before expiry", 2'd1, 2'd1);
    ticks(1); chk("R12 climb wins", 2'd0, 2'd0);
    hold_ms = 16'd3;

    // R13 level beyond shortened list
    sig_ok = 2'b00; ticks(6); chk("R13 at level 2", 2'd2, 2'd2);
    @(negedge clk) prio_cnt = 2'd2; @(negedge clk);
    chk("R13 back to 0", 2'd0, 2'd0);

    // R11 manual
    prio_cnt = 2'd3; manual = 1; man_src = 2'd1; do_reset();
    ticks(5); chk("R11 manual stays", 2'd1, 2'd0);
    @(negedge clk) man_src = 2'd2; @(negedge clk);
    chk("R11 manual generator", 2'd2, 2'd0);

    // R13 length code 0, R1 reset uses first entry
    manual = 0; prio_cnt = 2'd0; prio_list = {2'd2, 2'd0, 2'd1}; sig_ok = 2'b11; do_reset();
    chk("R1 reset first entry", 2'd1, 2'd0);
    sig_ok = 2'b00; ticks(5);
    chk("R13 single entry", 2'd1, 2'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule